// File: doc/BRIEF.md
# Masked-Write Core Reset and Flush Control Register

This block is a single 32-bit control register for one processor core. It drives the core's reset line and a cache-flush request, and it reports when a reset sequence has finished. Every write carries its own bit mask: the upper half of the write data selects which lower-half bits the write may change. Unselected bits keep their value, so software can update one field without reading the register first.

The flush request is set by software and cleared by the block when the flush-done input pulses. The reset follows one of two schemes, chosen at build time. In the self-clearing scheme, one write starts a timed sequence. The reset is held for a programmed number of ticks and released by hardware, and the done flag rises after a second programmed wait. In the software-cleared scheme, software sets and clears the reset bit itself, and the done flag rises a programmed wait after software releases the reset. The done flag is cleared by writing 1 to it, with its mask bit set.

Each wait is given in ticks of `TICK_CYCLES` clocks, from 1 to 15 ticks.

Top module: `cpu_rst_reg`

## Requirements
- R1: On a write, a lower-half bit k (k = 0, 4 or 12) changes only when data bit k+16 is 1. With that mask bit at 0, bit k keeps its value.
- R2: The read value has the reset bit at bit 0, the flush request at bit 4 and the done flag at bit 12. Every other bit, including all of [31:16], reads as 0.
- R3: `core_rst` always equals the current value of register bit 0.
- R4: A write with bit 20 set loads bit 4 from data bit 4, and `flush_req` equals bit 4. A `flush_done` pulse clears bit 4 one clock later. A masked write to bit 4 in the same cycle takes priority over the pulse.
- R5: Once bit 4 is set, it stays 1 for as long as no `flush_done` pulse and no masked write to bit 4 arrive.
- R6: Self-clearing scheme: a masked write of 1 to bit 0 while idle holds the reset for exactly APPLY_TICKS*TICK_CYCLES clocks, then hardware clears bit 0. Writes to bit 0 are ignored until the whole sequence has ended.
- R7: Self-clearing scheme: the done flag rises exactly RELEASE_TICKS*TICK_CYCLES clocks after the reset falls.
- R8: Software-cleared scheme: bit 0 takes the value of each masked write. A masked write of 0 while bit 0 is 1 starts a wait of RELEASE_TICKS*TICK_CYCLES clocks, after which the done flag rises. A masked write of 1 during that wait cancels it, and the done flag does not rise.
- R9: A write with bits 28 and 12 both 1 clears the done flag. Bit 28 alone, or bit 12 alone, does not clear it. If hardware sets the flag in the same cycle, the set wins.
- R10: After reset, the read value is 0 and both `core_rst` and `flush_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: mask in [31:16], values in [15:0] |
| bus_rdata | output | 32 | Current register contents |
| flush_done | input | 1 | Pulse that marks completion of the cache flush |
| flush_req | output | 1 | Cache flush request |
| core_rst | output | 1 | Reset to the core, active high |

## Verification
The assertions assume that `bus_wr`, `bus_wdata` and `flush_done` are always at known levels and only change between clock edges. They also assume that `flush_done` may coincide with a write in any cycle. The bench changes its inputs a moment after each rising edge and keeps the strobe high for exactly one clock per write. It deliberately makes flush-done collide with a flush write, and it makes done-clear writes collide with the hardware setting of the done flag. Two instances, one for each reset scheme, receive the same input stream, and a behavioural model of both is compared on every clock.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
   // register field positions; the mask for field k sits at k + MASK_SHIFT
   localparam int RST_POS    = 0;
   localparam int FLUSH_POS  = 4;
   localparam int DONE_POS   = 12;
   localparam int MASK_SHIFT = 16;
   localparam int MAX_TICKS  = 15;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_APPLY  = 2'd1,
      SEQ_REMOVE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cpu_rst_timer.sv
module cpu_rst_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
   import cpu_rst_pkg::*;
#(
   parameter bit AUTO_CLEAR    = 1'b1,
   parameter int TICK_CYCLES   = 4,
   parameter int APPLY_TICKS   = 3,
   parameter int RELEASE_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_rst,
   input  logic wr_val,
   output logic rst_bit,
   output logic done_set
);
   localparam int APPLY_CYC = APPLY_TICKS * TICK_CYCLES;
   localparam int REL_CYC   = RELEASE_TICKS * TICK_CYCLES;
   localparam int CW        = $clog2(MAX_TICKS * TICK_CYCLES + 1);
   localparam logic [CW-1:0] APPLY_LD = CW'(APPLY_CYC - 1);
   localparam logic [CW-1:0] REL_LD   = CW'(REL_CYC - 1);

   seq_state_e    st_q, st_d;
   logic          rst_q, rst_d;
   logic          ld;
   logic [CW-1:0] ld_val;
   logic          expired;

   cpu_rst_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .run      (st_q != SEQ_IDLE),
      .expired  (expired)
   );

   generate
      if (AUTO_CLEAR) begin : g_auto
         always_comb begin
            st_d     = st_q;
            rst_d    = rst_q;
            ld       = 1'b0;
            ld_val   = APPLY_LD;
            done_set = 1'b0;
            unique case (st_q)
               SEQ_IDLE: begin
                  if (wr_rst && wr_val) begin
                     rst_d  = 1'b1;
                     st_d   = SEQ_APPLY;
                     ld     = 1'b1;
                     ld_val = APPLY_LD;
                  end
               end
               SEQ_APPLY: begin
                  if (expired) begin
                     rst_d  = 1'b0;
                     st_d   = SEQ_REMOVE;
                     ld     = 1'b1;
                     ld_val = REL_LD;
                  end
               end
               SEQ_REMOVE: begin
                  if (expired) begin
                     done_set = 1'b1;
                     st_d     = SEQ_IDLE;
                  end
               end
               default: st_d = SEQ_IDLE;
            endcase
         end

         // R6
         apply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == SEQ_APPLY && !expired) |=> rst_q);
         // R7
         done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_set |-> !rst_q);
      end else begin : g_manual
         always_comb begin
            st_d     = st_q;
            rst_d    = rst_q;
            ld       = 1'b0;
            ld_val   = REL_LD;
            done_set = 1'b0;
            if (st_q == SEQ_REMOVE) begin
               if (wr_rst && wr_val) begin
                  st_d = SEQ_IDLE;
               end else if (expired) begin
                  done_set = 1'b1;
                  st_d     = SEQ_IDLE;
               end
            end
            if (wr_rst) begin
               rst_d = wr_val;
               if (rst_q && !wr_val) begin
                  st_d   = SEQ_REMOVE;
                  ld     = 1'b1;
                  ld_val = REL_LD;
               end
            end
         end

         // R8
         manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_rst |=> $stable(rst_q));
         // R8
         manual_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_set |-> (!rst_q && !(wr_rst && wr_val)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         rst_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rst_q <= rst_d;
      end
   end

   assign rst_bit = rst_q;
endmodule

// File: rtl/cpu_rst_flush.sv
module cpu_rst_flush (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_flush,
   input  logic wr_val,
   input  logic flush_done,
   output logic flush_bit
);
   logic flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flush_q <= 1'b0;
      else if (wr_flush)   flush_q <= wr_val;
      else if (flush_done) flush_q <= 1'b0;
   end

   assign flush_bit = flush_q;

   // R4
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_done && !wr_flush) |=> !flush_q);
   // R5
   flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !flush_done && !wr_flush) |=> flush_q);
endmodule

// File: rtl/cpu_rst_reg.sv
module cpu_rst_reg
   import cpu_rst_pkg::*;
#(
   parameter bit AUTO_CLEAR    = 1'b1,
   parameter int TICK_CYCLES   = 4,
   parameter int APPLY_TICKS   = 3,
   parameter int RELEASE_TICKS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        flush_done,
   output logic        flush_req,
   output logic        core_rst
);
   generate
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("TICK_CYCLES must be at least 1");
      end
      if (APPLY_TICKS < 1 || APPLY_TICKS > MAX_TICKS) begin : g_bad_apply
         $error("APPLY_TICKS out of range 1..15");
      end
      if (RELEASE_TICKS < 1 || RELEASE_TICKS > MAX_TICKS) begin : g_bad_release
         $error("RELEASE_TICKS out of range 1..15");
      end
   endgenerate

   logic wr_rst, wr_flush, wr_done_clr;
   logic rst_bit, flush_bit, done_set;
   logic done_q;

   assign wr_rst      = bus_wr && bus_wdata[RST_POS + MASK_SHIFT];
   assign wr_flush    = bus_wr && bus_wdata[FLUSH_POS + MASK_SHIFT];
   assign wr_done_clr = bus_wr && bus_wdata[DONE_POS + MASK_SHIFT] && bus_wdata[DONE_POS];

   cpu_rst_seq #(
      .AUTO_CLEAR    (AUTO_CLEAR),
      .TICK_CYCLES   (TICK_CYCLES),
      .APPLY_TICKS   (APPLY_TICKS),
      .RELEASE_TICKS (RELEASE_TICKS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_rst   (wr_rst),
      .wr_val   (bus_wdata[RST_POS]),
      .rst_bit  (rst_bit),
      .done_set (done_set)
   );

   cpu_rst_flush u_flush (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_flush   (wr_flush),
      .wr_val     (bus_wdata[FLUSH_POS]),
      .flush_done (flush_done),
      .flush_bit  (flush_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           done_q <= 1'b0;
      else if (done_set)    done_q <= 1'b1;
      else if (wr_done_clr) done_q <= 1'b0;
   end

   always_comb begin
      bus_rdata            = '0;
      bus_rdata[RST_POS]   = rst_bit;
      bus_rdata[FLUSH_POS] = flush_bit;
      bus_rdata[DONE_POS]  = done_q;
   end

   assign flush_req = flush_bit;
   assign core_rst  = rst_bit;

   // R9
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done_clr && !done_set) |=> !bus_rdata[DONE_POS]);
   // R1
   done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wr && bus_wdata[DONE_POS + MASK_SHIFT]) && !done_set) |=> $stable(done_q));
   // R9
   done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> bus_rdata[DONE_POS]);
endmodule

// File: tb/cpu_rst_reg_tb.sv
module cpu_rst_reg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TICKC = 4;
   localparam int APT   = 3;
   localparam int RLT   = 2;
   localparam int APPLY_CYC = APT * TICKC;
   localparam int REL_CYC   = RLT * TICKC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        flush_done = 1'b0;
   logic [31:0] rd_a, rd_m;
   logic        fr_a, fr_m, cr_a, cr_m;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_rst_reg #(.AUTO_CLEAR(1'b1), .TICK_CYCLES(TICKC), .APPLY_TICKS(APT),
                 .RELEASE_TICKS(RLT)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(rd_a), .flush_done(flush_done), .flush_req(fr_a), .core_rst(cr_a));

   cpu_rst_reg #(.AUTO_CLEAR(1'b0), .TICK_CYCLES(TICKC), .APPLY_TICKS(APT),
                 .RELEASE_TICKS(RLT)) u_dut_man (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(rd_m), .flush_done(flush_done), .flush_req(fr_m), .core_rst(cr_m));

   // behavioural model: index 1 = self-clearing, index 0 = software-cleared
   int m_rst[2], m_fl[2], m_done[2], m_ph[2], m_cnt[2];

   always @(posedge clk) begin
      for (int m = 0; m < 2; m++) begin
         int ds;
         bit wr16, wd0;
         if (!rst_n) begin
            m_rst[m] = 0; m_fl[m] = 0; m_done[m] = 0; m_ph[m] = 0; m_cnt[m] = 0;
         end else begin
            ds   = 0;
            wr16 = bus_wr && bus_wdata[16];
            wd0  = bus_wdata[0];
            if (bus_wr && bus_wdata[20]) m_fl[m] = bus_wdata[4];
            else if (flush_done)         m_fl[m] = 0;
            if (m == 1) begin
               if (m_ph[m] == 0) begin
                  if (wr16 && wd0) begin m_rst[m] = 1; m_ph[m] = 1; m_cnt[m] = APPLY_CYC - 1; end
               end else if (m_ph[m] == 1) begin
                  if (m_cnt[m] == 0) begin m_rst[m] = 0; m_ph[m] = 2; m_cnt[m] = REL_CYC - 1; end
                  else m_cnt[m]--;
               end else begin
                  if (m_cnt[m] == 0) begin ds = 1; m_ph[m] = 0; end
                  else m_cnt[m]--;
               end
            end else begin
               int old_rst;
               old_rst = m_rst[m];
               if (m_ph[m] == 2) begin
                  if (wr16 && wd0)        m_ph[m] = 0;
                  else if (m_cnt[m] == 0) begin ds = 1; m_ph[m] = 0; end
                  else m_cnt[m]--;
               end
               if (wr16) begin
                  m_rst[m] = wd0;
                  if (old_rst == 1 && !wd0) begin m_ph[m] = 2; m_cnt[m] = REL_CYC - 1; end
               end
            end
            if (ds) m_done[m] = 1;
            else if (bus_wr && bus_wdata[28] && bus_wdata[12]) m_done[m] = 0;
         end
      end
   end

   function automatic logic [31:0] exp_rd(int m);
      return 32'(m_rst[m]) | (32'(m_fl[m]) << 4) | (32'(m_done[m]) << 12);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison, away from the rising edge
   always @(negedge clk) begin
      chk("R2 self-clearing rdata", rd_a, exp_rd(1));
      chk("R2 sw-cleared rdata",    rd_m, exp_rd(0));
      chk("R3 self-clearing core_rst", {31'b0, cr_a}, 32'(m_rst[1]));
      chk("R3 sw-cleared core_rst",    {31'b0, cr_m}, 32'(m_rst[0]));
      chk("R4 self-clearing flush_req", {31'b0, fr_a}, 32'(m_fl[1]));
      chk("R4 sw-cleared flush_req",    {31'b0, fr_m}, 32'(m_fl[0]));
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
         summary();
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   task automatic wr(logic [31:0] d, logic fd = 1'b0);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_wdata = d; flush_done = fd;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_wdata = '0; flush_done = 1'b0;
   endtask

   task automatic pulse_fd();
      @(posedge clk); #1; flush_done = 1'b1;
      @(posedge clk); #1; flush_done = 1'b0;
   endtask

   initial begin
      int n;
      step(3);
      // R10: reset state
      chk("R10 rdata after reset", rd_a | rd_m, 32'h0);
      chk("R10 outputs after reset", {30'b0, cr_a | cr_m, fr_a | fr_m}, 32'h0);
      rst_n = 1'b1;
      step(2);

      // R6 / R7: timed self-clearing sequence
      wr(32'h0001_0001);
      chk("R8 sw-cleared reset set by write", {31'b0, cr_m}, 32'h1);
      n = 0;
      while (cr_a && n < 100) begin n++; step(1); end
      chk("R6 reset hold length", 32'(n), 32'(APPLY_CYC));
      n = 0;
      while (!rd_a[12] && n < 100) begin n++; step(1); end
      chk("R7 release to done length", 32'(n), 32'(REL_CYC));

      // R1: writes without mask change nothing
      wr(32'h0000_1011);
      chk("R1 unmasked write ignored", rd_a, 32'h0000_1000);
      chk("R1 unmasked write ignored sw", rd_m[4:0], 5'b00001);
      // R9: partial clear attempts
      wr(32'h1000_0000);
      chk("R9 mask without data keeps done", {31'b0, rd_a[12]}, 32'h1);
      wr(32'h0000_1000);
      chk("R9 data without mask keeps done", {31'b0, rd_a[12]}, 32'h1);
      wr(32'h1000_1000);
      chk("R9 clear done", {31'b0, rd_a[12]}, 32'h0);

      // R8: software release and done after wait
      wr(32'h0001_0000);
      chk("R8 release by write", {31'b0, cr_m}, 32'h0);
      step(REL_CYC + 1);
      chk("R8 done after wait", {31'b0, rd_m[12]}, 32'h1);
      wr(32'h1000_1000);

      // R8: cancel the wait by re-asserting
      wr(32'h0001_0001);
      step(APPLY_CYC + REL_CYC + 2);
      wr(32'h0001_0000);
      step(2);
      wr(32'h0001_0001);
      step(REL_CYC + 4);
      chk("R8 cancelled wait leaves done 0", {31'b0, rd_m[12]}, 32'h0);
      wr(32'h0001_0000);
      step(REL_CYC + 2);
      wr(32'h1000_1000);

      // R6: writes during sequence are ignored
      step(APPLY_CYC + REL_CYC);
      wr(32'h1000_1000);
      wr(32'h0001_0001);
      wr(32'h0001_0000);
      chk("R6 clear during sequence ignored", {31'b0, cr_a}, 32'h1);
      step(APPLY_CYC + REL_CYC + 2);
      wr(32'h1000_1000);

      // R4 / R5: flush handshake
      wr(32'h0010_0010);
      step(40);
      chk("R5 flush held without done", {31'b0, fr_a & fr_m}, 32'h1);
      pulse_fd();
      chk("R4 flush cleared by done pulse", {31'b0, fr_a | fr_m}, 32'h0);
      wr(32'h0010_0010, 1'b1);
      chk("R4 write wins over done pulse", {31'b0, fr_a}, 32'h1);
      wr(32'h0010_0000);
      chk("R4 masked write clears flush", {31'b0, fr_a}, 32'h0);

      // R9: set and clear colliding
      wr(32'h0001_0001);
      for (int i = 0; i < APPLY_CYC + REL_CYC + 4; i++) begin
         @(posedge clk); #1; bus_wr = 1'b1; bus_wdata = 32'h1000_1000;
      end
      @(posedge clk); #1; bus_wr = 1'b0; bus_wdata = '0;
      step(2);

      // R2: all-ones write
      wr(32'hFFFF_FFFF);
      chk("R2 upper half reads 0", {16'b0, rd_m[31:16]}, 32'h0);
      chk("R2 unused bits read 0", rd_m & ~32'h0000_1011, 32'h0);
      step(APPLY_CYC + REL_CYC + 4);
      summary();
   end
endmodule